// File: doc/BRIEF.md
# Limited-Pointer Coherence Directory

This block is the home directory for a set of memory blocks shared by a group of processors. Each block has one entry. The entry holds a coherence state and a small, fixed number of sharer slots. Each slot is a valid bit plus a processor ID, so the entry size does not grow with the processor count.

The directory handles three kinds of request: read, write and evict. It accepts one request at a time. Each request is worked out against the current entry for its block. If the request needs copies removed elsewhere, the directory sends one invalidation pulse that carries a target mask. It then counts acknowledgements from the caches. When the count is complete, it sends a single reply to the requester and writes back the updated entry.

A read can arrive when every slot is already in use. In that case the entry moves to a coarse broadcast state, and individual sharers are no longer tracked. The next write to that entry invalidates every processor except the writer. That write also returns the entry to precise tracking, with the writer as the only owner.

Top module: `lptr_dir`

## Requirements
- R1: After reset, req_ready_o is 1, inv_valid_o is 0 and rsp_valid_o is 0, and every entry is uncached. A first read of any block therefore causes no invalidation.
- R2: A read (req_type_i = 0) to an uncached or shared entry by a processor not yet tracked behaves as follows when a slot is free:
  - it takes the lowest free slot;
  - it causes no invalidation;
  - it gets a reply with rsp_excl_o = 0 and rsp_dst_o equal to the requester.
- R3: A read by a processor already held in a valid slot allocates no second slot.
- R4: A read by a non-owner to a modified entry sends one invalidation whose mask has only the owner's bit set, and it waits for one acknowledgement. It then replies with rsp_excl_o = 0. Afterwards the requester is the only tracked sharer.
- R5: A write (req_type_i = 1) invalidates every tracked sharer other than the writer. Bit i of inv_mask_o stands for processor i. The reply, with rsp_excl_o = 1, comes only after as many acknowledgements as the mask has set bits. The entry then becomes modified, with the writer as its only tracked holder.
- R6: A read by an untracked processor when all NUM_PTRS slots are valid causes no invalidation. It moves the entry to the broadcast state, in which no slot is valid.
- R7: A write to an entry in the broadcast state sends a mask with every bit set except the writer's, and it waits for NUM_PROCS-1 acknowledgements. Afterwards the entry is modified with the writer alone, so the next write by another processor invalidates only that writer.
- R8: An eviction (req_type_i = 2) by a tracked processor frees its slot for reuse. When no slot is left valid, the entry becomes uncached. An eviction by an untracked processor, or to an entry in the broadcast state, changes nothing. Every eviction gets a reply with rsp_excl_o = 0 and no invalidation.
- R9: req_ready_o is 1 only while the block is idle, and then neither inv_valid_o nor rsp_valid_o is 1. Each invalidation and each reply is a single-cycle pulse.
- R10: A read or a write by the current owner of a modified entry causes no invalidation and is answered directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Directory idle; the request is taken on this edge |
| req_type_i | input | 2 | 0 read, 1 write, 2 evict |
| req_src_i | input | $clog2(NUM_PROCS) | Requesting processor |
| req_blk_i | input | $clog2(NUM_BLOCKS) | Block index |
| inv_valid_o | output | 1 | Invalidation pulse |
| inv_mask_o | output | NUM_PROCS | Processors to invalidate, bit i = processor i |
| ack_valid_i | input | 1 | One invalidation acknowledgement this cycle |
| rsp_valid_o | output | 1 | Reply pulse |
| rsp_dst_o | output | $clog2(NUM_PROCS) | Processor the reply goes to |
| rsp_excl_o | output | 1 | 1 when exclusive ownership is granted |

## Verification
The embedded assertions check on every cycle that:
- requests are accepted only while idle;
- invalidation and reply pulses last one cycle;
- an invalidation never targets the requester;
- the acknowledgement counter never underflows;
- a modified entry holds exactly one valid slot;
- uncached and broadcast entries hold none.

Only the bench scenarios can show the end-to-end effects: which slot a read takes, that a freed slot is reused rather than causing overflow, that a repeated read does not fill a slot, and the exact masks and acknowledgement counts after overflow and after a write clears it. The bench shows these by comparing the masks and replies of later requests against a scoreboard.

// File: rtl/lptr_dir_pkg.sv
package lptr_dir_pkg;
  typedef enum logic [1:0] {ST_UNC = 2'd0, ST_SHR = 2'd1, ST_MOD = 2'd2, ST_BC = 2'd3} dstate_e;
  typedef enum logic [1:0] {RQ_RD = 2'd0, RQ_WR = 2'd1, RQ_EV = 2'd2, RQ_NOP = 2'd3} rq_e;
endpackage

// File: rtl/dir_entry_mem.sv
module dir_entry_mem
  import lptr_dir_pkg::*;
#(
  parameter int NB = 8,
  parameter int K  = 2,
  parameter int PW = 2,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [BW-1:0]         rd_blk_i,
  output dstate_e               rd_st_o,
  output logic [K-1:0]          rd_pv_o,
  output logic [K-1:0][PW-1:0]  rd_pid_o,
  input  logic                  we_i,
  input  logic [BW-1:0]         wr_blk_i,
  input  dstate_e               wr_st_i,
  input  logic [K-1:0]          wr_pv_i,
  input  logic [K-1:0][PW-1:0]  wr_pid_i
);
  dstate_e              st_q  [NB];
  logic [K-1:0]         pv_q  [NB];
  logic [K-1:0][PW-1:0] pid_q [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) begin
        st_q[b]  <= ST_UNC;
        pv_q[b]  <= '0;
        pid_q[b] <= '0;
      end
    end else if (we_i) begin
      st_q[wr_blk_i]  <= wr_st_i;
      pv_q[wr_blk_i]  <= wr_pv_i;
      pid_q[wr_blk_i] <= wr_pid_i;
    end
  end

  assign rd_st_o  = st_q[rd_blk_i];
  assign rd_pv_o  = pv_q[rd_blk_i];
  assign rd_pid_o = pid_q[rd_blk_i];

  for (genvar b = 0; b < NB; b++) begin : g_chk
    p_mod_one_owner_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[b] == ST_MOD) |-> ($countones(pv_q[b]) == 1));
    p_bc_no_ptr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[b] == ST_BC) |-> (pv_q[b] == '0));
    p_unc_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[b] == ST_UNC) |-> (pv_q[b] == '0));
  end
endmodule

// File: rtl/dir_next_entry.sv
module dir_next_entry
  import lptr_dir_pkg::*;
#(
  parameter int N  = 4,
  parameter int K  = 2,
  parameter int PW = 2
) (
  input  rq_e                   typ_i,
  input  logic [PW-1:0]         src_i,
  input  dstate_e               st_i,
  input  logic [K-1:0]          pv_i,
  input  logic [K-1:0][PW-1:0]  pid_i,
  output dstate_e               st_o,
  output logic [K-1:0]          pv_o,
  output logic [K-1:0][PW-1:0]  pid_o,
  output logic [N-1:0]          mask_o,
  output logic                  excl_o
);
  logic [K-1:0] hit, free_oh;
  logic         hit_any, free_any;
  logic [N-1:0] tracked, self_oh;

  always_comb begin
    hit      = '0;
    free_oh  = '0;
    free_any = 1'b0;
    for (int k = 0; k < K; k++) begin
      hit[k] = pv_i[k] && (pid_i[k] == src_i);
      if (!pv_i[k] && !free_any) begin
        free_oh[k] = 1'b1;
        free_any   = 1'b1;
      end
    end
    hit_any = |hit;
  end

  always_comb begin
    tracked = '0;
    self_oh = '0;
    for (int p = 0; p < N; p++) begin
      self_oh[p] = (src_i == PW'(p));
      for (int k = 0; k < K; k++)
        if (pv_i[k] && (pid_i[k] == PW'(p))) tracked[p] = 1'b1;
    end
  end

  always_comb begin
    st_o   = st_i;
    pv_o   = pv_i;
    pid_o  = pid_i;
    mask_o = '0;
    excl_o = 1'b0;
    unique case (typ_i)
      RQ_RD: begin
        unique case (st_i)
          ST_UNC, ST_SHR: begin
            if (!hit_any) begin
              if (free_any) begin
                st_o = ST_SHR;
                pv_o = pv_i | free_oh;
                for (int k = 0; k < K; k++)
                  if (free_oh[k]) pid_o[k] = src_i;
              end else begin
                st_o = ST_BC;  // coarse: untracked sharers
                pv_o = '0;
              end
            end
          end
          ST_MOD: begin
            if (!hit_any) begin
              mask_o   = tracked;
              st_o     = ST_SHR;
              pv_o     = '0;
              pv_o[0]  = 1'b1;
              pid_o[0] = src_i;
            end
          end
          default: ;
        endcase
      end
      RQ_WR: begin
        excl_o   = 1'b1;
        mask_o   = ((st_i == ST_BC) ? {N{1'b1}} : tracked) & ~self_oh;
        st_o     = ST_MOD;
        pv_o     = '0;
        pv_o[0]  = 1'b1;
        pid_o[0] = src_i;
      end
      RQ_EV: begin
        if (st_i != ST_BC && hit_any) begin
          pv_o = pv_i & ~hit;
          if ((pv_i & ~hit) == '0) st_o = ST_UNC;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_ack_cnt.sv
module dir_ack_cnt #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (dec_i)  cnt_o <= cnt_o - 1'b1;
  end

  p_no_underflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_o != '0));
endmodule

// File: rtl/lptr_dir.sv
module lptr_dir
  import lptr_dir_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_PTRS   = 2,
  parameter int NUM_BLOCKS = 8,
  localparam int PID_W = (NUM_PROCS > 1) ? $clog2(NUM_PROCS) : 1,
  localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int CNT_W = $clog2(NUM_PROCS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic [1:0]           req_type_i,
  input  logic [PID_W-1:0]     req_src_i,
  input  logic [BLK_W-1:0]     req_blk_i,
  output logic                 inv_valid_o,
  output logic [NUM_PROCS-1:0] inv_mask_o,
  input  logic                 ack_valid_i,
  output logic                 rsp_valid_o,
  output logic [PID_W-1:0]     rsp_dst_o,
  output logic                 rsp_excl_o
);
  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_INV, S_WAIT, S_RESP} fsm_e;

  fsm_e                              state_q, state_d;
  rq_e                               typ_q;
  logic [PID_W-1:0]                  src_q;
  logic [BLK_W-1:0]                  blk_q;
  dstate_e                           cur_st, nxt_st, st_q;
  logic [NUM_PTRS-1:0]               cur_pv, nxt_pv, pv_q;
  logic [NUM_PTRS-1:0][PID_W-1:0]    cur_pid, nxt_pid, pid_q;
  logic [NUM_PROCS-1:0]              nxt_mask, mask_q;
  logic                              nxt_excl, excl_q;
  logic [CNT_W-1:0]                  ack_cnt;
  logic                              take, look, ack_dec;

  function automatic logic [CNT_W-1:0] popc(logic [NUM_PROCS-1:0] m);
    logic [CNT_W-1:0] c = '0;
    for (int i = 0; i < NUM_PROCS; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  assign req_ready_o = (state_q == S_IDLE);
  assign take        = req_valid_i && req_ready_o;
  assign look        = (state_q == S_LOOK);
  assign ack_dec     = (state_q == S_WAIT) && ack_valid_i;
  assign inv_valid_o = (state_q == S_INV);
  assign inv_mask_o  = mask_q;
  assign rsp_valid_o = (state_q == S_RESP);
  assign rsp_dst_o   = src_q;
  assign rsp_excl_o  = excl_q;

  dir_entry_mem #(.NB(NUM_BLOCKS), .K(NUM_PTRS), .PW(PID_W)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_blk_i (blk_q),
    .rd_st_o  (cur_st),
    .rd_pv_o  (cur_pv),
    .rd_pid_o (cur_pid),
    .we_i     (rsp_valid_o),
    .wr_blk_i (blk_q),
    .wr_st_i  (st_q),
    .wr_pv_i  (pv_q),
    .wr_pid_i (pid_q)
  );

  dir_next_entry #(.N(NUM_PROCS), .K(NUM_PTRS), .PW(PID_W)) u_next (
    .typ_i  (typ_q),
    .src_i  (src_q),
    .st_i   (cur_st),
    .pv_i   (cur_pv),
    .pid_i  (cur_pid),
    .st_o   (nxt_st),
    .pv_o   (nxt_pv),
    .pid_o  (nxt_pid),
    .mask_o (nxt_mask),
    .excl_o (nxt_excl)
  );

  dir_ack_cnt #(.CW(CNT_W)) u_ack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (look),
    .load_val_i (popc(nxt_mask)),
    .dec_i      (ack_dec),
    .cnt_o      (ack_cnt)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (take) state_d = S_LOOK;
      S_LOOK: state_d = (nxt_mask != '0) ? S_INV : S_RESP;
      S_INV:  state_d = S_WAIT;
      S_WAIT: if (ack_valid_i && ack_cnt == CNT_W'(1)) state_d = S_RESP;
      S_RESP: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      typ_q   <= RQ_NOP;
      src_q   <= '0;
      blk_q   <= '0;
      st_q    <= ST_UNC;
      pv_q    <= '0;
      pid_q   <= '0;
      mask_q  <= '0;
      excl_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        typ_q <= rq_e'(req_type_i);
        src_q <= req_src_i;
        blk_q <= req_blk_i;
      end
      if (look) begin
        st_q   <= nxt_st;
        pv_q   <= nxt_pv;
        pid_q  <= nxt_pid;
        mask_q <= nxt_mask;
        excl_q <= nxt_excl;
      end
    end
  end

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!inv_valid_o && !rsp_valid_o));
  p_inv_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |=> !inv_valid_o);
  p_rsp_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> (!rsp_valid_o && req_ready_o));
  p_no_self_inv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> (!inv_mask_o[src_q] && inv_mask_o != '0));
endmodule

// File: tb/lptr_dir_tb_top.sv
`timescale 1ns/1ps
module lptr_dir_tb_top;
  localparam int NP = 4;
  localparam int PW = 2;
  localparam int BW = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [1:0]    req_type_i = '0;
  logic [PW-1:0] req_src_i = '0;
  logic [BW-1:0] req_blk_i = '0;
  logic          inv_valid_o;
  logic [NP-1:0] inv_mask_o;
  logic          ack_valid_i = 1'b0;
  logic          rsp_valid_o;
  logic [PW-1:0] rsp_dst_o;
  logic          rsp_excl_o;

  always #2.5 clk_i = ~clk_i;

  lptr_dir #(.NUM_PROCS(NP), .NUM_PTRS(2), .NUM_BLOCKS(8)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_type_i, .req_src_i,
    .req_blk_i, .inv_valid_o, .inv_mask_o, .ack_valid_i, .rsp_valid_o,
    .rsp_dst_o, .rsp_excl_o
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R1";
  logic [NP-1:0] exp_inv [$];
  logic [PW:0]   exp_rsp [$];
  int ack_pend = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // type: 0 read, 1 write, 2 evict; imask 0 means no invalidation expected
  task automatic do_req(input logic [1:0] t, input int src, input int blk,
                        input logic [NP-1:0] imask, input bit excl, input string tag);
    cur_tag = tag;
    if (imask != '0) exp_inv.push_back(imask);
    exp_rsp.push_back({excl, PW'(src)});
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R9", "ready before request", int'(req_ready_o), 1);
    req_valid_i = 1'b1;
    req_type_i  = t;
    req_src_i   = PW'(src);
    req_blk_i   = BW'(blk);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R9", "ready while busy", int'(req_ready_o), 0);
    while (exp_rsp.size() != 0) @(negedge clk_i);
    chk(exp_inv.size() == 0, tag, "missing invalidation", exp_inv.size(), 0);
    exp_inv.delete();
  endtask

  // monitor and ack responder
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (rsp_valid_o) begin
          chk(ack_pend == 0, cur_tag, "reply before all acks", ack_pend, 0);
          if (exp_rsp.size() == 0) begin
            chk(1'b0, cur_tag, "unexpected reply", int'({rsp_excl_o, rsp_dst_o}), 0);
          end else begin
            logic [PW:0] e;
            e = exp_rsp.pop_front();
            chk({rsp_excl_o, rsp_dst_o} == e, cur_tag, "reply {excl,dst}",
                int'({rsp_excl_o, rsp_dst_o}), int'(e));
          end
        end
        if (ack_pend > 0) begin
          ack_valid_i = 1'b1;
          ack_pend--;
        end else begin
          ack_valid_i = 1'b0;
        end
        if (inv_valid_o) begin
          if (exp_inv.size() == 0) begin
            chk(1'b0, cur_tag, "unexpected invalidation", int'(inv_mask_o), 0);
          end else begin
            logic [NP-1:0] m;
            m = exp_inv.pop_front();
            chk(inv_mask_o == m, cur_tag, "invalidation mask", int'(inv_mask_o), int'(m));
          end
          ack_pend = $countones(inv_mask_o);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1", "ready in reset", int'(req_ready_o), 1);
    chk(inv_valid_o == 1'b0, "R1", "inv in reset", int'(inv_valid_o), 0);
    chk(rsp_valid_o == 1'b0, "R1", "rsp in reset", int'(rsp_valid_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R1", "ready after reset", int'(req_ready_o), 1);

    // block 0: fill two slots, repeat read, write by third processor
    do_req(2'd0, 0, 0, 4'b0000, 0, "R1");
    do_req(2'd0, 1, 0, 4'b0000, 0, "R2");
    do_req(2'd0, 1, 0, 4'b0000, 0, "R3");
    do_req(2'd1, 2, 0, 4'b0011, 1, "R5");
    // block 1: overflow, broadcast write, then precise again
    do_req(2'd0, 0, 1, 4'b0000, 0, "R2");
    do_req(2'd0, 1, 1, 4'b0000, 0, "R2");
    do_req(2'd0, 2, 1, 4'b0000, 0, "R6");
    do_req(2'd1, 3, 1, 4'b0111, 1, "R7");
    do_req(2'd1, 0, 1, 4'b1000, 1, "R7");
    // block 2: eviction frees a slot for reuse; untracked evict ignored
    do_req(2'd0, 0, 2, 4'b0000, 0, "R2");
    do_req(2'd0, 1, 2, 4'b0000, 0, "R2");
    do_req(2'd2, 0, 2, 4'b0000, 0, "R8");
    do_req(2'd0, 2, 2, 4'b0000, 0, "R8");
    do_req(2'd2, 3, 2, 4'b0000, 0, "R8");
    do_req(2'd1, 3, 2, 4'b0110, 1, "R8");
    // block 3: read of modified block by non-owner
    do_req(2'd1, 1, 3, 4'b0000, 1, "R5");
    do_req(2'd0, 2, 3, 4'b0010, 0, "R4");
    do_req(2'd1, 3, 3, 4'b0100, 1, "R4");
    // block 4: broadcast write by a former sharer
    do_req(2'd0, 0, 4, 4'b0000, 0, "R2");
    do_req(2'd0, 1, 4, 4'b0000, 0, "R2");
    do_req(2'd0, 2, 4, 4'b0000, 0, "R6");
    do_req(2'd1, 1, 4, 4'b1101, 1, "R7");
    // block 5: eviction in broadcast state is ignored
    do_req(2'd0, 0, 5, 4'b0000, 0, "R6");
    do_req(2'd0, 1, 5, 4'b0000, 0, "R6");
    do_req(2'd0, 2, 5, 4'b0000, 0, "R6");
    do_req(2'd2, 0, 5, 4'b0000, 0, "R8");
    do_req(2'd1, 3, 5, 4'b0111, 1, "R8");
    // block 6: owner evicts, entry uncached
    do_req(2'd1, 0, 6, 4'b0000, 1, "R5");
    do_req(2'd2, 0, 6, 4'b0000, 0, "R8");
    do_req(2'd0, 1, 6, 4'b0000, 0, "R8");
    do_req(2'd1, 2, 6, 4'b0010, 1, "R5");
    // block 7: owner hits
    do_req(2'd1, 2, 7, 4'b0000, 1, "R5");
    do_req(2'd1, 2, 7, 4'b0000, 1, "R10");
    do_req(2'd0, 2, 7, 4'b0000, 0, "R10");
    do_req(2'd1, 1, 7, 4'b0100, 1, "R10");
    // block 0 again: writer 2 is sole owner
    do_req(2'd1, 0, 0, 4'b0100, 1, "R5");

    repeat (4) @(negedge clk_i);
    chk(rsp_valid_o == 1'b0 && inv_valid_o == 1'b0, "R9", "quiet at end",
        int'({inv_valid_o, rsp_valid_o}), 0);
    finish_sim();
  end
endmodule